// File: doc/BRIEF.md
# Deflection Controller Serial Register Interface

This block is the serial control port of a display deflection controller. It acts as a slave on a two-wire I2C bus. It holds the bank of write-only adjustment and control registers, and it returns one read-only status byte. SCL and SDA are sampled with the system clock, which must run at least 16 times the bus bit rate. START, repeated START and STOP are recognised. A write message carries the device address, then a subaddress, then any number of data bytes. The subaddress steps up by one after each data byte. A repeated START inside a message begins a new address phase, so a fresh subaddress can be set without releasing the bus.

Written data lands first in a shadow copy. The whole shadow bank is moved to the active outputs when the vertical-retrace strobe pulses. There are two exceptions. The line-duty register and the supply-reference register take effect as soon as their byte is acknowledged, provided bit 7 of the written byte is 0. Two command bits in the command register do not store. Each produces a one-cycle clear pulse on the acknowledge of its byte.

A read transaction returns the status byte no matter which subaddress was last set. The status byte is built from flags supplied by the sync and safety logic. A supply-monitor input that reports "not normal" silences the interface and returns every register to its power-on value.

Top module: `defl_regif`

## Requirements
- R1: Only the address byte 8Ch (write) or 8Dh (read) is acknowledged. After any other address byte the block never pulls SDA low and changes no register until the next START.
- R2: In a write message, the first byte after the address sets the subaddress, and each following data byte goes to the current subaddress, which then steps up by one. A repeated START followed by the write address begins a new subaddress phase.
- R3: The active register outputs change only on a cycle after a vertical-retrace strobe, when every active register takes its shadow value. The exceptions are the immediate cases of R4 and R5 and supply loss (R6).
- R4: A byte written to subaddress 00h or 03h whose bit 7 is 0 reaches the active output directly after its acknowledge. The same byte with bit 7 at 1 waits for the retrace strobe.
- R5: In a byte written to subaddress 16h, bit 4 makes a one-cycle pulse on `sdet_clr_o` and bit 7 makes a one-cycle pulse on `xray_clr_o`, each issued at the acknowledge. Both bits are stored as 0.
- R6: While `supply_ok_i` is 0, SDA is never pulled and no byte is acknowledged. One cycle later every register, shadow and active, holds its power-on default.
- R7: A read returns the status byte for every byte the master acknowledges, whatever subaddress was set before. The read ends when the master answers with NAK.
- R8: Status bits 6..0 equal `stat_flags_i`. Bit 7 equals `h_unlock_i` when bit 2 of register 17h is 1. Otherwise bit 7 equals the inverse of bit 3 of register 1Fh.
- R9: Data bytes sent to a subaddress of 20h or above are acknowledged and discarded.
- R10: After reset, registers 00h..0Fh hold 40h, registers 10h..1Fh hold 00h, SDA is released and both clear pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply monitor reports normal operation |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| vretrace_i | input | 1 | One-cycle strobe at vertical oscillator discharge |
| stat_flags_i | input | 7 | Status flags for bits 6..0 of the status byte |
| h_unlock_i | input | 1 | Horizontal loop not locked |
| regs_o | output | NUM_REGS*8 | Active registers, register n in bits n*8+7..n*8 |
| sdet_clr_o | output | 1 | Sync-detect flag clear pulse |
| xray_clr_o | output | 1 | Over-voltage alarm clear pulse |

## Verification
The bound checker watches four things on every cycle. The active outputs stay stable unless a retrace strobe or a byte commit occurred on the cycle before. Each clear pulse lasts one cycle and always follows a commit. The two command bits never appear as 1 in the outputs. Supply loss releases SDA and restores the defaults on the next cycle.

Other behaviour appears only across a whole bus transaction, so only the bench scenarios can show it. This covers address matching, subaddress stepping across a repeated START, the choice between immediate and deferred application, discarding of writes past the register bank, and the value read back in the status byte. The bench's reference model tracks both register copies and is compared against the outputs whenever the bus is quiet.

// File: rtl/regif_pkg.sv
package regif_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_e;

  // 7-bit device address: 8Ch write, 8Dh read
  localparam logic [6:0] DEV_ADDR = 7'h46;

  // register positions that other logic decodes
  localparam int DUTY_IDX  = 0;
  localparam int BREF_IDX  = 3;
  localparam int CMD_IDX   = 22;
  localparam int CTRL_IDX  = 23;
  localparam int IDENT_IDX = 31;
  localparam int LIVE_BIT  = 7;
  localparam int SDET_BIT  = 4;
  localparam int XRAY_BIT  = 7;
  localparam int OUTEN_BIT = 2;
  localparam int IDENT_BIT = 3;
  localparam int MEDIUM_REGS = 16;

  function automatic logic [7:0] reg_default(input int idx);
    return (idx < MEDIUM_REGS) ? 8'h40 : 8'h00;
  endfunction

  function automatic logic [7:0] status_compose(input logic [6:0] flags,
                                                input logic h_unlock,
                                                input logic out_en,
                                                input logic ident);
    return {(out_en ? h_unlock : ~ident), flags};
  endfunction

  function automatic logic takes_effect_now(input logic [7:0] sub,
                                            input logic [7:0] data);
    return ((sub == 8'(DUTY_IDX)) || (sub == 8'(BREF_IDX))) && !data[LIVE_BIT];
  endfunction

  function automatic logic [7:0] strip_cmd(input logic [7:0] sub,
                                           input logic [7:0] data);
    logic [7:0] r;
    r = data;
    if (sub == 8'(CMD_IDX)) begin
      r[SDET_BIT] = 1'b0;
      r[XRAY_BIT] = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/regif_bus_sync.sv
module regif_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic scl_d;
  logic sda_d;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/regif_i2c_slave.sv
module regif_i2c_slave
  import regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_ok,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] status_byte,
  output logic       sda_pull,
  output logic       wr_ev,
  output logic [7:0] wr_sub,
  output logic [7:0] wr_data
);
  bus_state_e st;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic [7:0] sub;
  logic [3:0] bitcnt;
  logic       have_sub;
  logic       rd_mode;
  logic       rd_acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      tx       <= '0;
      sub      <= '0;
      bitcnt   <= '0;
      have_sub <= 1'b0;
      rd_mode  <= 1'b0;
      rd_acked <= 1'b0;
      sda_pull <= 1'b0;
      wr_ev    <= 1'b0;
      wr_sub   <= '0;
      wr_data  <= '0;
    end else if (!bus_ok) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      have_sub <= 1'b0;
      sda_pull <= 1'b0;
      wr_ev    <= 1'b0;
    end else begin
      wr_ev <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        have_sub <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  st       <= ST_ADDR_ACK;
                  sda_pull <= 1'b1;
                  rd_mode  <= shreg[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_SUB) begin
                sub      <= shreg;
                have_sub <= 1'b1;
                st       <= ST_SUB_ACK;
                sda_pull <= 1'b1;
              end else begin
                wr_ev    <= 1'b1;
                wr_sub   <= sub;
                wr_data  <= shreg;
                sub      <= sub + 8'd1;
                st       <= ST_DATA_ACK;
                sda_pull <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                st       <= ST_RD;
                tx       <= status_byte;
                sda_pull <= ~status_byte[7];
                bitcnt   <= '0;
              end else begin
                st       <= have_sub ? ST_DATA : ST_SUB;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_SUB_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              st       <= ST_DATA;
              sda_pull <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                st       <= ST_RD_ACK;
                sda_pull <= 1'b0;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_pull <= ~tx[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              rd_acked <= ~sda_s;
            end else if (scl_fall) begin
              if (rd_acked) begin
                st       <= ST_RD;
                tx       <= status_byte;
                sda_pull <= ~status_byte[7];
                bitcnt   <= '0;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regif_regbank.sv
module regif_regbank
  import regif_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_ok,
  input  logic                  wr_ev,
  input  logic [7:0]            wr_sub,
  input  logic [7:0]            wr_data,
  input  logic                  vretrace,
  output logic [NUM_REGS*8-1:0] regs_flat,
  output logic                  sdet_clr,
  output logic                  xray_clr
);
  logic [7:0] shadow [NUM_REGS];
  logic [7:0] active [NUM_REGS];
  logic       hit;
  logic       now;
  logic [7:0] wval;

  assign hit  = wr_ev && (int'(wr_sub) < NUM_REGS);
  assign now  = takes_effect_now(wr_sub, wr_data);
  assign wval = strip_cmd(wr_sub, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        shadow[i] <= reg_default(i);
        active[i] <= reg_default(i);
      end
      sdet_clr <= 1'b0;
      xray_clr <= 1'b0;
    end else if (!bus_ok) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        shadow[i] <= reg_default(i);
        active[i] <= reg_default(i);
      end
      sdet_clr <= 1'b0;
      xray_clr <= 1'b0;
    end else begin
      sdet_clr <= hit && (wr_sub == 8'(CMD_IDX)) && wr_data[SDET_BIT];
      xray_clr <= hit && (wr_sub == 8'(CMD_IDX)) && wr_data[XRAY_BIT];
      for (int i = 0; i < NUM_REGS; i++) begin
        if (vretrace) active[i] <= shadow[i];
        if (hit && (wr_sub == 8'(i))) begin
          shadow[i] <= wval;
          if (now) active[i] <= wval;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = active[g];
  end
endmodule

// File: rtl/defl_regif.sv
module defl_regif
  import regif_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  supply_ok_i,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic                  vretrace_i,
  input  logic [6:0]            stat_flags_i,
  input  logic                  h_unlock_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  sdet_clr_o,
  output logic                  xray_clr_o
);
  logic       sda_s;
  logic       scl_rise_w;
  logic       scl_fall_w;
  logic       start_w;
  logic       stop_w;
  logic       commit_w;
  logic [7:0] commit_sub_w;
  logic [7:0] commit_data_w;
  logic [7:0] status_w;

  regif_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
  );

  assign status_w = status_compose(stat_flags_i, h_unlock_i,
                                   regs_o[CTRL_IDX*8 + OUTEN_BIT],
                                   regs_o[IDENT_IDX*8 + IDENT_BIT]);

  regif_i2c_slave proto_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ok      (supply_ok_i),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise_w),
    .scl_fall    (scl_fall_w),
    .start_det   (start_w),
    .stop_det    (stop_w),
    .status_byte (status_w),
    .sda_pull    (sda_pull_o),
    .wr_ev       (commit_w),
    .wr_sub      (commit_sub_w),
    .wr_data     (commit_data_w)
  );

  regif_regbank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ok    (supply_ok_i),
    .wr_ev     (commit_w),
    .wr_sub    (commit_sub_w),
    .wr_data   (commit_data_w),
    .vretrace  (vretrace_i),
    .regs_flat (regs_o),
    .sdet_clr  (sdet_clr_o),
    .xray_clr  (xray_clr_o)
  );
endmodule

// File: rtl/regif_checker.sv
module regif_checker
  import regif_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  supply_ok_i,
  input logic                  vretrace_i,
  input logic                  commit_w,
  input logic                  sda_pull_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  sdet_clr_o,
  input logic                  xray_clr_o
);
  function automatic logic [NUM_REGS*8-1:0] all_defaults();
    logic [NUM_REGS*8-1:0] r;
    for (int i = 0; i < NUM_REGS; i++) r[i*8 +: 8] = reg_default(i);
    return r;
  endfunction

  localparam logic [NUM_REGS*8-1:0] DEF_FLAT = all_defaults();

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok_i && !vretrace_i && !commit_w) |=> $stable(regs_o)); // R3

  AST_SDET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sdet_clr_o |=> !sdet_clr_o); // R5

  AST_XRAY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xray_clr_o |=> !xray_clr_o); // R5

  AST_CLR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sdet_clr_o || xray_clr_o) |-> $past(commit_w)); // R5

  AST_CMD_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(regs_o[CMD_IDX*8 + SDET_BIT] || regs_o[CMD_IDX*8 + XRAY_BIT])); // R5

  AST_SUPPLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> !sda_pull_o); // R6

  AST_SUPPLY_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (regs_o == DEF_FLAT)); // R6
endmodule

bind defl_regif regif_checker #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok_i (supply_ok_i),
  .vretrace_i  (vretrace_i),
  .commit_w    (commit_w),
  .sda_pull_o  (sda_pull_o),
  .regs_o      (regs_o),
  .sdet_clr_o  (sdet_clr_o),
  .xray_clr_o  (xray_clr_o)
);

// File: tb/defl_regif_tb_top.sv
module defl_regif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic vretrace = 1'b0;
  logic [6:0] flags = 7'h00;
  logic h_unlock = 1'b0;
  logic sda_pull;
  logic sda_bus;
  logic [NREG*8-1:0] regs;
  logic sdet_clr, xray_clr;

  int nchecks = 0;
  int nerrors = 0;
  int sdet_cnt = 0;
  int xray_cnt = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  int exp_shadow [NREG];
  int exp_active [NREG];
  logic [7:0] pay [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  defl_regif #(.NUM_REGS(NREG)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_pull_o   (sda_pull),
    .vretrace_i   (vretrace),
    .stat_flags_i (flags),
    .h_unlock_i   (h_unlock),
    .regs_o       (regs),
    .sdet_clr_o   (sdet_clr),
    .xray_clr_o   (xray_clr)
  );

  always @(posedge clk) begin
    if (sdet_clr) sdet_cnt++;
    if (xray_clr) xray_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_defaults();
    for (int i = 0; i < NREG; i++) begin
      exp_shadow[i] = (i <= 15) ? 'h40 : 'h00;
      exp_active[i] = exp_shadow[i];
    end
  endtask

  task automatic model_write(input int s, input logic [7:0] d);
    int v;
    if (s >= NREG) return;
    v = d;
    if (s == 'h16) v = v & 'h6F;
    exp_shadow[s] = v;
    if ((s == 0 || s == 3) && !d[7]) exp_active[s] = v;
  endtask

  function automatic int reg_out(input int i);
    return int'(regs[i*8 +: 8]);
  endfunction

  // per-clock comparison of the outputs against the reference model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      int bad;
      bad = -1;
      for (int i = 0; i < NREG; i++)
        if (reg_out(i) != exp_active[i] && bad < 0) bad = i;
      nchecks++;
      if (bad >= 0) begin
        nerrors++;
        $display("FAIL R3 model reg %0h actual=%0h expected=%0h",
                 bad, reg_out(bad), exp_active[bad]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    cmp_en = 1'b0;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
    tick(4);
    cmp_en = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus};
      tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // write message: device byte, subaddress, n bytes from pay[]
  task automatic wr_msg(input logic [7:0] dev, input int sub, input int n,
                        output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte(dev, a);
    if (a) begin
      acks++;
      send_byte(8'(sub), a);
      if (a) acks++;
      for (int k = 0; k < n; k++) begin
        send_byte(pay[k], a);
        if (a) begin
          acks++;
          model_write((sub + k) & 'hFF, pay[k]);
        end
      end
    end
    bus_stop();
  endtask

  task automatic retrace();
    cmp_en = 1'b0;
    vretrace = 1'b1; tick(1);
    vretrace = 1'b0;
    for (int i = 0; i < NREG; i++) exp_active[i] = exp_shadow[i];
    tick(2);
    cmp_en = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerrors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int acks;
    bit a;
    logic [7:0] rb;
    model_defaults();
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10 reset state
    chk("R10 reg00", reg_out(0), 'h40);
    chk("R10 reg0F", reg_out(15), 'h40);
    chk("R10 reg10", reg_out(16), 'h00);
    chk("R10 sda released", int'(sda_pull), 0);
    chk("R10 clear pulses", int'(sdet_clr | xray_clr), 0);
    cmp_en = 1'b1;

    // R2 R3 auto-increment, deferred until retrace
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3;
    wr_msg(8'h8C, 5, 3, acks);
    chk("R2 acks", acks, 5);
    chk("R3 reg05 before retrace", reg_out(5), 'h40);
    retrace();
    chk("R2 reg05", reg_out(5), 'hA1);
    chk("R2 reg06", reg_out(6), 'hB2);
    chk("R2 reg07", reg_out(7), 'hC3);

    // R2 repeated START changes subaddress
    bus_start();
    send_byte(8'h8C, a); send_byte(8'h0A, a);
    send_byte(8'h11, a); if (a) model_write('h0A, 8'h11);
    bus_rstart();
    send_byte(8'h8C, a); chk("R2 ack after rstart", int'(a), 1);
    send_byte(8'h12, a);
    send_byte(8'h22, a); if (a) model_write('h12, 8'h22);
    bus_stop();
    retrace();
    chk("R2 reg0A", reg_out('h0A), 'h11);
    chk("R2 reg12 after rstart", reg_out('h12), 'h22);
    chk("R2 reg0B untouched", reg_out('h0B), 'h40);

    // R4 immediate duty and supply-reference registers
    pay[0] = 8'h35;
    wr_msg(8'h8C, 0, 1, acks);
    chk("R4 reg00 immediate", reg_out(0), 'h35);
    pay[0] = 8'h85;
    wr_msg(8'h8C, 0, 1, acks);
    chk("R4 reg00 bit7 deferred", reg_out(0), 'h35);
    pay[0] = 8'h12;
    wr_msg(8'h8C, 1, 1, acks);
    chk("R4 reg01 deferred", reg_out(1), 'h40);
    pay[0] = 8'h12;
    wr_msg(8'h8C, 3, 1, acks);
    chk("R4 reg03 immediate", reg_out(3), 'h12);
    retrace();
    chk("R4 reg00 after retrace", reg_out(0), 'h85);
    chk("R4 reg01 after retrace", reg_out(1), 'h12);

    // R5 self-clearing command bits
    sdet_cnt = 0; xray_cnt = 0;
    pay[0] = 8'h93;
    wr_msg(8'h8C, 'h16, 1, acks);
    chk("R5 sdet pulse", sdet_cnt, 1);
    chk("R5 xray pulse", xray_cnt, 1);
    retrace();
    chk("R5 reg16 stored", reg_out('h16), 'h03);
    sdet_cnt = 0; xray_cnt = 0;
    pay[0] = 8'h10;
    wr_msg(8'h8C, 'h16, 1, acks);
    chk("R5 sdet only", sdet_cnt, 1);
    chk("R5 no xray", xray_cnt, 0);

    // R1 foreign address
    pay[0] = 8'h77;
    wr_msg(8'h90, 2, 1, acks);
    chk("R1 no ack", acks, 0);
    retrace();
    chk("R1 reg02 untouched", reg_out(2), 'h40);

    // R9 out-of-range subaddress and wrap past the bank
    pay[0] = 8'h5A;
    wr_msg(8'h8C, 'h40, 1, acks);
    chk("R9 ack beyond bank", acks, 3);
    pay[0] = 8'h08; pay[1] = 8'h99;
    wr_msg(8'h8C, 'h1F, 2, acks);
    chk("R9 acks across end", acks, 4);
    retrace();
    chk("R9 reg1F", reg_out('h1F), 'h08);
    chk("R9 reg00 untouched", reg_out(0), 'h85);

    // R7 R8 status reads
    flags = 7'h2B; h_unlock = 1'b1;
    wr_msg(8'h8C, 5, 0, acks);
    bus_start();
    send_byte(8'h8D, a); chk("R7 read ack", int'(a), 1);
    read_byte(rb, 1'b1);
    chk("R8 ident set, out off", int'(rb), 'h2B);
    read_byte(rb, 1'b0);
    chk("R7 repeated status", int'(rb), 'h2B);
    bus_stop();
    pay[0] = 8'h00;
    wr_msg(8'h8C, 'h1F, 1, acks);
    retrace();
    bus_start(); send_byte(8'h8D, a); read_byte(rb, 1'b0); bus_stop();
    chk("R8 ident clear, out off", int'(rb), 'hAB);
    pay[0] = 8'h04;
    wr_msg(8'h8C, 'h17, 1, acks);
    retrace();
    h_unlock = 1'b0;
    bus_start(); send_byte(8'h8D, a); read_byte(rb, 1'b0); bus_stop();
    chk("R8 out on follows unlock", int'(rb), 'h2B);

    // R6 supply loss
    cmp_en = 1'b0;
    supply_ok = 1'b0; tick(3);
    model_defaults();
    chk("R6 reg05 default", reg_out(5), 'h40);
    chk("R6 reg17 default", reg_out('h17), 'h00);
    pay[0] = 8'h66;
    bus_start(); send_byte(8'h8C, a); bus_stop();
    chk("R6 no ack", int'(a), 0);
    cmp_en = 1'b0;
    supply_ok = 1'b1; tick(4);
    cmp_en = 1'b1;
    pay[0] = 8'h2C;
    wr_msg(8'h8C, 3, 1, acks);
    chk("R6 recovers", reg_out(3), 'h2C);
    tick(20);
    finish_run();
  end
endmodule